// File: doc/BRIEF.md
# IQ Mismatch Coefficient Calculator

This block turns receive-path I/Q imbalance measurements into correction coefficients for each receive chain. A measurement engine offers one word per chain per round: I-branch power, Q-branch power and the I·Q cross-correlation. The block sums these words in 32-bit accumulators and counts the rounds. A clear pulse begins a new measurement campaign.

A start pulse runs the compute sequence. Chains are visited in ascending index order, and only those set in the chain-enable mask are processed. For each enabled chain the block derives two denominators from the accumulated powers. It folds the sign out of the correlation and runs two divisions on one shared restoring divider, which takes 32 cycles per quotient. The results are a 6-bit phase coefficient and a 5-bit saturated gain coefficient. When every chain has been handled, the block pulses `done` and raises `corr_en`, the global correction-enable.

The measurement input is a valid/ready stream. A word is taken on a clock edge where `smp_valid` and `smp_ready` are both high. `smp_ready` is low for the whole compute sequence. While it is low, the producer must hold its word and keep `smp_valid` high. The start, clear, mask and coefficient pins are plain levels and pulses.

Top module: `iq_coef_calc`

## Requirements
- R1: On each accepted measurement word, every chain's I power, Q power and correlation accumulator adds its 32-bit input modulo 2^32, and `smp_count` increments by one.
- R2: `clr` while idle zeroes all accumulators and `smp_count` on the next edge and drops `corr_en`; while busy, `clr` has no effect.
- R3: The correlation sum is folded as follows. If it is strictly greater than 0x80000000 when read as unsigned, it is replaced by its two's-complement magnitude and flagged negative. Otherwise, including exactly 0x80000000, it is used as-is and is not negative.
- R4: The phase denominator is ((P_I>>1)+(P_Q>>1))>>7 and the gain denominator is P_Q>>6. All divisions truncate.
- R5: A chain is updated only when P_Q, the phase denominator and the gain denominator are all nonzero. Otherwise its `coef_valid` bit stays 0 and its coefficients keep their previous values.
- R6: Let p be the low 6 bits of magnitude / phase denominator. The phase coefficient is p when the correlation is negative, and (64 - p) mod 64 otherwise.
- R7: The gain coefficient is P_I / gain denominator - 64, computed without overflow and clamped to -16..15. It is presented as 5-bit two's complement.
- R8: A chain whose `chain_en` bit was 0 at start is skipped: `coef_valid` bit 0, coefficients held.
- R9: `start` while idle clears `coef_valid` and `corr_en`. After the last chain, `done` is high for exactly one cycle and `corr_en` rises with it and stays high until the next start or clear.
- R10: `smp_ready` is low while `busy`. A word offered then is not taken and changes neither the count nor the results.
- R11: `start` while busy is ignored: the running sequence and its mask are unchanged.
- R12: After reset, `smp_ready` is 1 and `busy`, `done`, `corr_en`, `coef_valid` and `smp_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Begin a new campaign (zero sums and count) |
| smp_valid | input | 1 | Measurement word offered |
| smp_ready | output | 1 | Measurement word can be taken |
| smp_pwr_i | input | NCHAIN*32 | I power per chain, chain c at bits [32c+31:32c] |
| smp_pwr_q | input | NCHAIN*32 | Q power per chain |
| smp_corr | input | NCHAIN*32 | Signed I·Q correlation per chain |
| smp_count | output | CNT_W | Rounds accepted since last clear |
| start | input | 1 | Begin coefficient computation |
| chain_en | input | NCHAIN | Chains to process, sampled at start |
| busy | output | 1 | Compute sequence running |
| done | output | 1 | One-cycle completion pulse |
| corr_en | output | 1 | Global correction enable |
| coef_valid | output | NCHAIN | Chain updated by the last run |
| phase_coef | output | NCHAIN*6 | Phase coefficient, chain c at bits [6c+5:6c] |
| gain_coef | output | NCHAIN*5 | Gain coefficient, chain c at bits [5c+4:5c] |

## Verification
A corrupted accumulator does not show up when it happens. It appears only at the next `done`, as a wrong phase or gain value on that chain, or as a chain that should have been skipped or updated and was not. The round counter, by contrast, is visible on `smp_count` one cycle after each handshake. A divider or sequencing fault shows as a wrong quotient in the low phase bits or in the clamp region, or as a `done` that arrives late or never. The bench therefore compares every chain's outputs at each completion against an independent model. It also drives sign-boundary, skip and saturation cases that would otherwise hide such faults.

// File: rtl/iqc_pkg.sv
`timescale 1ns/1ps
package iqc_pkg;
  localparam int ACC_W   = 32;
  localparam int PHASE_W = 6;
  localparam int GAIN_W  = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHK,
    ST_PH,
    ST_GN,
    ST_FIN
  } seq_state_t;

  function automatic logic [PHASE_W-1:0] fold_phase(input logic [PHASE_W-1:0] p,
                                                    input logic neg);
    return neg ? p : PHASE_W'(PHASE_W'(0) - p);
  endfunction

  function automatic logic [GAIN_W-1:0] sat_gain(input logic [ACC_W-1:0] q);
    logic signed [ACC_W+1:0] g;
    g = $signed({2'b00, q}) - (ACC_W+2)'(64);
    if (g > (ACC_W+2)'(15))       return GAIN_W'(15);
    else if (g < -(ACC_W+2)'(16)) return GAIN_W'(5'b10000);
    else                          return g[GAIN_W-1:0];
  endfunction
endpackage

// File: rtl/iqc_accum.sv
`timescale 1ns/1ps
module iqc_accum #(
  parameter int NCHAIN = 3,
  parameter int W      = 32,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic                clr,
  input  logic [NCHAIN*W-1:0] in_i,
  input  logic [NCHAIN*W-1:0] in_q,
  input  logic [NCHAIN*W-1:0] in_c,
  output logic [NCHAIN*W-1:0] acc_i,
  output logic [NCHAIN*W-1:0] acc_q,
  output logic [NCHAIN*W-1:0] acc_c,
  output logic [CNT_W-1:0]    cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_i <= '0;
      acc_q <= '0;
      acc_c <= '0;
      cnt   <= '0;
    end else if (clr) begin
      acc_i <= '0;
      acc_q <= '0;
      acc_c <= '0;
      cnt   <= '0;
    end else if (take) begin
      for (int c = 0; c < NCHAIN; c++) begin
        acc_i[c*W +: W] <= acc_i[c*W +: W] + in_i[c*W +: W];
        acc_q[c*W +: W] <= acc_q[c*W +: W] + in_q[c*W +: W];
        acc_c[c*W +: W] <= acc_c[c*W +: W] + in_c[c*W +: W];
      end
      cnt <= cnt + 1'b1;
    end
  end

  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clr) |=> cnt == $past(cnt) + 1'b1);
  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && acc_i == '0 && acc_q == '0 && acc_c == '0));
  a_r10_hold_sums: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !clr) |=> ($stable(cnt) && $stable(acc_i) && $stable(acc_c)));
endmodule

// File: rtl/iqc_div.sv
`timescale 1ns/1ps
module iqc_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  num_l, den_l, quo_r;
  logic [W:0]    rem_r, trial;
  logic [CW-1:0] step;
  logic          run;

  assign trial = {rem_r[W-1:0], quo_r[W-1]};
  assign quo   = quo_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_l <= '0; den_l <= '0; quo_r <= '0; rem_r <= '0;
      step  <= '0; run   <= 1'b0; done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        num_l <= num; den_l <= den; quo_r <= num; rem_r <= '0;
        step  <= '0;  run   <= 1'b1;
      end else if (run) begin
        if (trial >= {1'b0, den_l}) begin
          rem_r <= trial - {1'b0, den_l};
          quo_r <= {quo_r[W-2:0], 1'b1};
        end else begin
          rem_r <= trial;
          quo_r <= {quo_r[W-2:0], 1'b0};
        end
        step <= step + 1'b1;
        if (step == CW'(W - 1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  a_r4_div_exact: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((2*W)'(quo_r) * (2*W)'(den_l) + (2*W)'(rem_r) == (2*W)'(num_l)));
  a_r4_div_rem_small: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rem_r < {1'b0, den_l}));
  a_r5_nonzero_den: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> den != '0);
endmodule

// File: rtl/iqc_prep.sv
`timescale 1ns/1ps
module iqc_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] pwr_i,
  input  logic [W-1:0] pwr_q,
  input  logic [W-1:0] corr,
  output logic [W-1:0] den_ph,
  output logic [W-1:0] den_gn,
  output logic [W-1:0] mag,
  output logic         neg,
  output logic         ok
);
  logic [W-1:0] half_sum;
  localparam logic [W-1:0] SIGN_EDGE = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    half_sum = {1'b0, pwr_i[W-1:1]} + {1'b0, pwr_q[W-1:1]};
    den_ph   = half_sum >> 7;
    den_gn   = pwr_q >> 6;
    neg      = corr > SIGN_EDGE;
    mag      = neg ? (~corr + 1'b1) : corr;
    ok       = (pwr_q != '0) && (den_ph != '0) && (den_gn != '0);
  end
endmodule

// File: rtl/iq_coef_calc.sv
`timescale 1ns/1ps
module iq_coef_calc
  import iqc_pkg::*;
#(
  parameter int NCHAIN = 3,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    smp_valid,
  output logic                    smp_ready,
  input  logic [NCHAIN*ACC_W-1:0] smp_pwr_i,
  input  logic [NCHAIN*ACC_W-1:0] smp_pwr_q,
  input  logic [NCHAIN*ACC_W-1:0] smp_corr,
  output logic [CNT_W-1:0]        smp_count,
  input  logic                    start,
  input  logic [NCHAIN-1:0]       chain_en,
  output logic                    busy,
  output logic                    done,
  output logic                    corr_en,
  output logic [NCHAIN-1:0]       coef_valid,
  output logic [NCHAIN*PHASE_W-1:0] phase_coef,
  output logic [NCHAIN*GAIN_W-1:0]  gain_coef
);
  localparam int IDX_W = $clog2(NCHAIN + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NCHAIN);

  seq_state_t st;
  logic [IDX_W-1:0]  idx, idx_c;
  logic [NCHAIN-1:0] mask_l;
  logic [PHASE_W-1:0] ph_q;
  logic [PHASE_W-1:0] ph_arr [NCHAIN];
  logic [GAIN_W-1:0]  gn_arr [NCHAIN];

  logic take, clr_eff;
  logic [NCHAIN*ACC_W-1:0] acc_i, acc_q, acc_c;
  logic [ACC_W-1:0] sel_i, sel_q, sel_c;
  logic [ACC_W-1:0] den_ph, den_gn, mag;
  logic neg, ok;
  logic div_go, div_done;
  logic [ACC_W-1:0] div_num, div_den, div_quo;

  assign smp_ready = (st == ST_IDLE);
  assign busy      = (st != ST_IDLE);
  assign take      = smp_valid && smp_ready;
  assign clr_eff   = clr && (st == ST_IDLE);
  assign idx_c     = (idx < LAST) ? idx : '0;

  iqc_accum #(.NCHAIN(NCHAIN), .W(ACC_W), .CNT_W(CNT_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .take(take), .clr(clr_eff),
    .in_i(smp_pwr_i), .in_q(smp_pwr_q), .in_c(smp_corr),
    .acc_i(acc_i), .acc_q(acc_q), .acc_c(acc_c), .cnt(smp_count)
  );

  always_comb begin
    sel_i = acc_i[idx_c*ACC_W +: ACC_W];
    sel_q = acc_q[idx_c*ACC_W +: ACC_W];
    sel_c = acc_c[idx_c*ACC_W +: ACC_W];
  end

  iqc_prep #(.W(ACC_W)) u_prep (
    .pwr_i(sel_i), .pwr_q(sel_q), .corr(sel_c),
    .den_ph(den_ph), .den_gn(den_gn), .mag(mag), .neg(neg), .ok(ok)
  );

  always_comb begin
    div_go  = 1'b0;
    div_num = mag;
    div_den = den_ph;
    if (st == ST_CHK && idx != LAST && mask_l[idx_c] && ok) begin
      div_go = 1'b1;
    end else if (st == ST_PH && div_done) begin
      div_go  = 1'b1;
      div_num = sel_i;
      div_den = den_gn;
    end
  end

  iqc_div #(.W(ACC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_num), .den(div_den),
    .done(div_done), .quo(div_quo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; idx <= '0; mask_l <= '0; ph_q <= '0;
      done <= 1'b0; corr_en <= 1'b0; coef_valid <= '0;
      for (int c = 0; c < NCHAIN; c++) begin
        ph_arr[c] <= '0;
        gn_arr[c] <= '0;
      end
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (clr_eff) corr_en <= 1'b0;
          if (start) begin
            st <= ST_CHK; idx <= '0; mask_l <= chain_en;
            coef_valid <= '0; corr_en <= 1'b0;
          end
        end
        ST_CHK: begin
          if (idx == LAST)    st  <= ST_FIN;
          else if (div_go)    st  <= ST_PH;
          else                idx <= idx + 1'b1;
        end
        ST_PH: begin
          if (div_done) begin
            ph_q <= div_quo[PHASE_W-1:0];
            st   <= ST_GN;
          end
        end
        ST_GN: begin
          if (div_done) begin
            ph_arr[idx_c]     <= fold_phase(ph_q, neg);
            gn_arr[idx_c]     <= sat_gain(div_quo);
            coef_valid[idx_c] <= 1'b1;
            idx <= idx + 1'b1;
            st  <= ST_CHK;
          end
        end
        ST_FIN: begin
          done    <= 1'b1;
          corr_en <= 1'b1;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  for (genvar c = 0; c < NCHAIN; c++) begin : g_out
    assign phase_coef[c*PHASE_W +: PHASE_W] = ph_arr[c];
    assign gain_coef[c*GAIN_W +: GAIN_W]    = gn_arr[c];
  end

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_enable_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> corr_en);
  a_r8_valid_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ((coef_valid & ~mask_l) == '0));
  a_r11_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mask_l));
  a_r10_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(smp_count));
endmodule

// File: tb/iq_coef_calc_bench.sv
`timescale 1ns/1ps
module iq_coef_calc_bench;
  localparam int NC = 3;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, smp_valid = 1'b0, start = 1'b0;
  logic smp_ready, busy, done, corr_en;
  logic [NC*32-1:0] smp_pwr_i = '0, smp_pwr_q = '0, smp_corr = '0;
  logic [CW-1:0] smp_count;
  logic [NC-1:0] chain_en = '0, coef_valid;
  logic [NC*6-1:0] phase_coef;
  logic [NC*5-1:0] gain_coef;

  int total = 0, bad = 0;
  bit [31:0] m_i[NC], m_q[NC], m_c[NC];
  int unsigned m_cnt = 0;
  bit [5:0] e_ph[NC];
  bit [4:0] e_gn[NC];
  bit e_v[NC];

  always #4 clk = ~clk;

  iq_coef_calc #(.NCHAIN(NC), .CNT_W(CW)) u_iq_coef_calc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_pwr_i(smp_pwr_i), .smp_pwr_q(smp_pwr_q), .smp_corr(smp_corr),
    .smp_count(smp_count), .start(start), .chain_en(chain_en), .busy(busy),
    .done(done), .corr_en(corr_en), .coef_valid(coef_valid),
    .phase_coef(phase_coef), .gain_coef(gain_coef)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model(input bit [31:0] pi, input bit [31:0] pq, input bit [31:0] cr,
                       output bit ok, output bit [5:0] ph, output bit [4:0] gn);
    bit [31:0] dph, dgn, mg;
    bit ng;
    longint g;
    dph = ((pi >> 1) + (pq >> 1)) >> 7;
    dgn = pq >> 6;
    ok  = (pq != 0) && (dph != 0) && (dgn != 0);
    ng  = cr > 32'h8000_0000;
    mg  = ng ? (32'd0 - cr) : cr;
    ph = 0; gn = 0;
    if (ok) begin
      ph = 6'(mg / dph);
      if (!ng) ph = 6'(7'd64 - {1'b0, ph});
      g = longint'(pi / dgn) - 64;
      if (g > 15) g = 15;
      else if (g < -16) g = -16;
      gn = 5'(g);
    end
  endtask

  task automatic do_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    for (int c = 0; c < NC; c++) begin m_i[c] = 0; m_q[c] = 0; m_c[c] = 0; end
    m_cnt = 0;
    check("R2 count cleared", smp_count, 0);
    check("R2 corr_en cleared", corr_en, 0);
  endtask

  task automatic send(input bit [31:0] a[NC], input bit [31:0] b[NC], input bit [31:0] d[NC]);
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      smp_pwr_i[c*32 +: 32] = a[c];
      smp_pwr_q[c*32 +: 32] = b[c];
      smp_corr[c*32 +: 32]  = d[c];
    end
    smp_valid = 1'b1;
    while (!smp_ready) @(negedge clk);
    @(negedge clk);
    smp_valid = 1'b0;
    for (int c = 0; c < NC; c++) begin
      m_i[c] += a[c]; m_q[c] += b[c]; m_c[c] += d[c];
    end
    m_cnt++;
    check("R1 count step", smp_count, m_cnt % 65536);
  endtask

  task automatic run(input bit [NC-1:0] mask, input bit disturb);
    int waitc;
    bit ok;
    bit [5:0] ph;
    bit [4:0] gn;
    @(negedge clk); start = 1'b1; chain_en = mask;
    @(negedge clk); start = 1'b0; chain_en = ~mask;
    check("R10 ready low while busy", smp_ready, 0);
    if (disturb) begin
      smp_valid = 1'b1; clr = 1'b1; start = 1'b1;
      smp_pwr_i = '1; smp_pwr_q = '1; smp_corr = '1;
      @(negedge clk);
      check("R10 ready still low", smp_ready, 0);
      smp_valid = 1'b0; clr = 1'b0; start = 1'b0;
    end
    waitc = 0;
    while (!done && waitc < 2000) begin @(negedge clk); waitc++; end
    check("R9 done seen", done, 1);
    check("R9 corr_en with done", corr_en, 1);
    for (int c = 0; c < NC; c++) begin
      model(m_i[c], m_q[c], m_c[c], ok, ph, gn);
      if (mask[c] && ok) begin e_ph[c] = ph; e_gn[c] = gn; e_v[c] = 1; end
      else e_v[c] = 0;
      check(mask[c] ? "R5 valid flag" : "R8 disabled chain flag", coef_valid[c], e_v[c]);
      check("R6 phase coef", phase_coef[c*6 +: 6], e_ph[c]);
      check("R7 gain coef", gain_coef[c*5 +: 5], e_gn[c]);
    end
    check("R2 R10 count after run", smp_count, m_cnt % 65536);
    @(negedge clk);
    check("R9 done single cycle", done, 0);
    check("R9 corr_en stays", corr_en, 1);
  endtask

  initial begin
    #1200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit [31:0] a[NC], b[NC], d[NC];
    int unsigned seed_v;
    seed_v = $urandom(32'd4242);
    for (int c = 0; c < NC; c++) begin e_ph[c] = 0; e_gn[c] = 0; e_v[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 ready after reset", smp_ready, 1);
    check("R12 busy after reset", busy, 0);
    check("R12 done after reset", done, 0);
    check("R12 corr_en after reset", corr_en, 0);
    check("R12 valid after reset", coef_valid, 0);
    check("R12 count after reset", smp_count, 0);

    // R3 sign boundary: 0x80000000 not negative, 0x80000001 negative; chain 2 has zero Q power (R5)
    do_clr();
    for (int c = 0; c < NC; c++) begin a[c] = 384; b[c] = 384; end
    b[2] = 0; d[0] = 32'h8000_0000; d[1] = 32'h8000_0001; d[2] = 5;
    send(a, b, d);
    run(3'b111, 1'b0);
    check("R3 exact edge phase", phase_coef[5:0], 22);
    check("R3 negative phase", phase_coef[11:6], 42);

    // R4/R5 zero phase denominator; R7 saturation high and low
    do_clr();
    a[0] = 100; b[0] = 100; a[1] = 32'hFFFF_0000; b[1] = 384; a[2] = 0; b[2] = 384;
    d[0] = 7; d[1] = 0; d[2] = 32'hFFFF_FF00;
    send(a, b, d);
    run(3'b111, 1'b0);
    check("R7 clamp high", gain_coef[9:5], 15);
    check("R7 clamp low", gain_coef[14:10], 5'b10000);
    check("R5 skipped chain holds", phase_coef[5:0], 22);

    // random campaigns, one with disturbance during busy (R10, R11, R2)
    for (int k = 0; k < 10; k++) begin
      int ns;
      bit [NC-1:0] mk;
      do_clr();
      ns = $urandom_range(1, 5);
      for (int s = 0; s < ns; s++) begin
        for (int c = 0; c < NC; c++) begin
          b[c] = $urandom_range(32'h1000, 32'h00FF_FFFF);
          a[c] = b[c] + $urandom_range(0, 32'h0008_0000) - 32'h0004_0000;
          d[c] = $urandom_range(0, 32'h0010_0000) - 32'h0008_0000;
        end
        send(a, b, d);
      end
      mk = NC'($urandom_range(1, (1 << NC) - 1));
      run(mk, k == 3 || k == 7);
    end

    // R2 clear ignored while busy: disturbed run above; check clear drops corr_en when idle
    do_clr();
    check("R2 corr_en off after clear", corr_en, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule